// File: doc/BRIEF.md
# Two-Wire Serial Controller Status Flags

This block keeps the completion, receive-ready, transmit-ready and negative-acknowledge flags of a two-wire serial controller that works either as bus master or as addressed slave. A separate bit-level engine reports what happens on the bus through single-cycle event strobes: start, repeated start, stop, an address phase with its match result, a byte received, a byte moved from the holding register into the shifter, a byte acknowledged, a NACK and a stop that the master has sent. The register front end adds a read strobe for the receive holding register, a write strobe for the transmit holding register, the master enable level and the mode select.

The flags are updated at the clock edge after the strobe and presented in a read-only 32-bit status word. The word has no write port, so software cannot change it. A fixed pattern of bits reads as one. The completion and transmit-ready flags follow one set of rules in master mode and a different set in slave mode. The mode input selects which set applies in each cycle. The flags keep their values when the mode changes.

Top module: `tws_status`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, the status word reads 0x0000F009. That is TXCOMP=1, RXRDY=0, TXRDY=0, NACK=0, with the fixed ones in place.
- R2: Bits 3, 12, 13, 14 and 15 of the status word always read 1. Every bit other than these and the four flag bits reads 0.
- R3: In master mode (mode_master=1), TXCOMP is bit 0. It clears one cycle after a start strobe. It sets one cycle after a stop-sent strobe, but only if no byte is waiting in the transmit holding register. A stop-sent strobe while a byte is waiting leaves TXCOMP at 0.
- R4: In slave mode (mode_master=0), TXCOMP clears one cycle after a start strobe and sets one cycle after a stop strobe.
- R5: In slave mode, an address strobe with addr_hit=0 sets TXCOMP only if a repeated start came earlier with no address strobe between the two. A non-matching address with no repeated start before it, or a matching address, leaves TXCOMP unchanged.
- R6: RXRDY is bit 1. It sets one cycle after a byte-received strobe and clears one cycle after a receive-holding read strobe. It stays 1 when another byte arrives while it is set. When a read and a byte arrive in the same cycle, RXRDY stays 1.
- R7: In master mode, TXRDY is bit 2. It clears one cycle after a transmit-holding write. It sets one cycle after a holding-to-shifter transfer.
- R8: In master mode, a NACK strobe sets TXCOMP, TXRDY and the NACK flag (bit 8) together, one cycle later. It also empties the transmit holding register. The NACK flag clears one cycle after the next start strobe.
- R9: A rising edge of the master enable, in either mode, sets TXRDY one cycle later. This includes master enable being held high through the release of reset.
- R10: In slave mode, a transmit-holding write clears TXRDY. A holding-to-shifter transfer does not set TXRDY again. Only an acknowledge strobe or a NACK strobe sets it.
- R11: When a write strobe and a transfer strobe for TXRDY arrive in the same cycle, the set wins and TXRDY reads 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| mode_master | input | 1 | 1 selects master rules, 0 selects slave rules |
| msen | input | 1 | Master enable level |
| ev_start | input | 1 | Start condition seen |
| ev_rstart | input | 1 | Repeated start seen |
| ev_stop | input | 1 | Stop condition seen |
| ev_addr | input | 1 | Address phase finished |
| addr_hit | input | 1 | Address matched own slave address (valid with ev_addr) |
| ev_rx_byte | input | 1 | Received byte placed in receive holding register |
| ev_xfer | input | 1 | Byte moved from transmit holding register to shifter |
| ev_tx_ack | input | 1 | Transmitted byte answered with ACK |
| ev_nack | input | 1 | Transmitted byte answered with NACK |
| ev_stop_sent | input | 1 | Master finished sending a stop |
| rhr_rd | input | 1 | Receive holding register read |
| thr_wr | input | 1 | Transmit holding register write |
| status | output | 32 | Read-only status word |

## Verification
The bench builds the block with its default parameters: a 32-bit word, the fixed-ones mask 0xF008, and flag positions 0, 1, 2 and 8. With these, every output bit can be compared to the exact reset value 0x0000F009. The flag positions, the fixed ones and the bits that must stay zero are all checked in one comparison. A single continuous sequence first runs the master rules and then the slave rules on the same flags. This shows mode-dependent behaviour such as a stop-sent blocked by a waiting byte, and a transfer that does not count in slave mode.

// File: rtl/tws_pkg.sv
// Shared types for the two-wire status flag unit.
// Assumes every event field is a single-cycle strobe from the bit engine.
package tws_pkg;

    // Event strobes and register accesses sampled in one cycle
    typedef struct packed {
        logic start;
        logic rstart;
        logic stop;
        logic addr;
        logic addr_hit;
        logic rx_byte;
        logic xfer;
        logic tx_ack;
        logic nack;
        logic stop_sent;
        logic rhr_rd;
        logic thr_wr;
    } tws_ev_t;

    // Index of each flag in the flag vectors
    typedef enum logic [1:0] {
        FL_TXCOMP = 2'd0,
        FL_RXRDY  = 2'd1,
        FL_TXRDY  = 2'd2,
        FL_NACK   = 2'd3
    } tws_flag_e;

    localparam int NUM_FLAGS = 4;

endpackage

// File: rtl/tws_flag.sv
// One status flag: a register with separate set and clear requests.
// A set request beats a clear request in the same cycle, so no event is lost.
// Assumes a synchronous active-low reset that loads RST_VAL.
module tws_flag #(
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic set_req,
    input  logic clr_req,
    output logic q
);

    // Flag register: reset value, then set-over-clear priority
    always_ff @(posedge clk) begin
        if (!rst_n)       q <= RST_VAL;
        else if (set_req) q <= 1'b1;
        else if (clr_req) q <= 1'b0;
    end

    p_reset_val_r1: assert property (@(posedge clk) !rst_n |=> q == RST_VAL);
    p_set_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
        set_req |=> q);
    p_clear_only_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_req && !set_req) |=> !q);

endmodule

// File: rtl/tws_track.sv
// Keeps the small amount of bus-phase state the flag rules need:
// whether a byte is waiting in the transmit holding register,
// whether a repeated start is waiting for its address phase,
// and the previous master enable level used to find its rising edge.
// Assumes strobes last one cycle. A transfer or a NACK beats a write.
module tws_track (
    input  logic clk,
    input  logic rst_n,
    input  logic msen,
    input  logic thr_wr,
    input  logic xfer,
    input  logic nack,
    input  logic rstart,
    input  logic addr,
    output logic hold_empty,
    output logic rs_pend,
    output logic msen_rise
);

    logic hold_full;
    logic msen_q;

    // Holding register occupancy: write fills, transfer or NACK empties
    always_ff @(posedge clk) begin
        if (!rst_n)            hold_full <= 1'b0;
        else if (xfer || nack) hold_full <= 1'b0;
        else if (thr_wr)       hold_full <= 1'b1;
    end

    // Repeated start waiting for the address phase that follows it
    always_ff @(posedge clk) begin
        if (!rst_n)      rs_pend <= 1'b0;
        else if (addr)   rs_pend <= 1'b0;
        else if (rstart) rs_pend <= 1'b1;
    end

    // Previous master enable level
    always_ff @(posedge clk) begin
        if (!rst_n) msen_q <= 1'b0;
        else        msen_q <= msen;
    end

    assign hold_empty = !hold_full;
    assign msen_rise  = msen && !msen_q;

    p_hold_fill_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (thr_wr && !xfer && !nack) |=> !hold_empty);
    p_rs_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        addr |=> !rs_pend);

endmodule

// File: rtl/tws_rules.sv
// Turns the event strobes into set and clear requests for every flag.
// Master and slave rules for TXCOMP and TXRDY are both computed and the
// mode input picks one. RXRDY, NACK and the master-enable rule do not
// depend on the mode. Purely combinational.
module tws_rules
    import tws_pkg::*;
(
    input  logic                 mode_master,
    input  tws_ev_t              ev,
    input  logic                 hold_empty,
    input  logic                 rs_pend,
    input  logic                 msen_rise,
    output logic [NUM_FLAGS-1:0] set_v,
    output logic [NUM_FLAGS-1:0] clr_v
);

    logic m_comp_set, m_comp_clr, m_rdy_set, m_rdy_clr;
    logic s_comp_set, s_comp_clr, s_rdy_set, s_rdy_clr;

    // Master rules: completion needs an empty holding register at stop-sent
    always_comb begin
        m_comp_set = (ev.stop_sent && hold_empty) || ev.nack;
        m_comp_clr = ev.start;
        m_rdy_set  = ev.xfer || ev.nack;
        m_rdy_clr  = ev.thr_wr;
    end

    // Slave rules: completion at stop or at a foreign address after a repeated start
    always_comb begin
        s_comp_set = ev.stop || (ev.addr && !ev.addr_hit && rs_pend);
        s_comp_clr = ev.start;
        s_rdy_set  = ev.tx_ack || ev.nack;
        s_rdy_clr  = ev.thr_wr;
    end

    // Request vectors for the flag cells
    always_comb begin
        set_v = '0;
        clr_v = '0;
        set_v[FL_TXCOMP] = mode_master ? m_comp_set : s_comp_set;
        clr_v[FL_TXCOMP] = mode_master ? m_comp_clr : s_comp_clr;
        set_v[FL_TXRDY]  = (mode_master ? m_rdy_set : s_rdy_set) || msen_rise;
        clr_v[FL_TXRDY]  = mode_master ? m_rdy_clr : s_rdy_clr;
        set_v[FL_RXRDY]  = ev.rx_byte;
        clr_v[FL_RXRDY]  = ev.rhr_rd;
        set_v[FL_NACK]   = ev.nack;
        clr_v[FL_NACK]   = ev.start;
    end

endmodule

// File: rtl/tws_status.sv
// Status flag unit of a two-wire serial controller (master or slave).
// It takes event strobes from the bit engine and register access strobes,
// keeps the flags, and shows them with fixed ones in a read-only word.
// Assumes synchronous active-low reset and single-cycle strobes.
module tws_status
    import tws_pkg::*;
#(
    parameter int          STAT_W     = 32,
    parameter logic [31:0] CONST_ONES = 32'h0000_F008,
    parameter int          POS_TXCOMP = 0,
    parameter int          POS_RXRDY  = 1,
    parameter int          POS_TXRDY  = 2,
    parameter int          POS_NACK   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_master,
    input  logic              msen,
    input  logic              ev_start,
    input  logic              ev_rstart,
    input  logic              ev_stop,
    input  logic              ev_addr,
    input  logic              addr_hit,
    input  logic              ev_rx_byte,
    input  logic              ev_xfer,
    input  logic              ev_tx_ack,
    input  logic              ev_nack,
    input  logic              ev_stop_sent,
    input  logic              rhr_rd,
    input  logic              thr_wr,
    output logic [STAT_W-1:0] status
);

    localparam logic [NUM_FLAGS-1:0] FLAG_RST = NUM_FLAGS'(1) << FL_TXCOMP;
    localparam logic [STAT_W-1:0]    FIXED    = CONST_ONES[STAT_W-1:0];

    tws_ev_t              ev;
    logic                 hold_empty, rs_pend, msen_rise;
    logic [NUM_FLAGS-1:0] set_v, clr_v, flag_q;

    // Gather the strobes into one event record
    always_comb begin
        ev = '{start: ev_start, rstart: ev_rstart, stop: ev_stop,
               addr: ev_addr, addr_hit: addr_hit, rx_byte: ev_rx_byte,
               xfer: ev_xfer, tx_ack: ev_tx_ack, nack: ev_nack,
               stop_sent: ev_stop_sent, rhr_rd: rhr_rd, thr_wr: thr_wr};
    end

    tws_track u_track (
        .clk        (clk),
        .rst_n      (rst_n),
        .msen       (msen),
        .thr_wr     (thr_wr),
        .xfer       (ev_xfer),
        .nack       (ev_nack),
        .rstart     (ev_rstart),
        .addr       (ev_addr),
        .hold_empty (hold_empty),
        .rs_pend    (rs_pend),
        .msen_rise  (msen_rise)
    );

    tws_rules u_rules (
        .mode_master (mode_master),
        .ev          (ev),
        .hold_empty  (hold_empty),
        .rs_pend     (rs_pend),
        .msen_rise   (msen_rise),
        .set_v       (set_v),
        .clr_v       (clr_v)
    );

    for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_flag
        tws_flag #(.RST_VAL(FLAG_RST[i])) u_flag (
            .clk     (clk),
            .rst_n   (rst_n),
            .set_req (set_v[i]),
            .clr_req (clr_v[i]),
            .q       (flag_q[i])
        );
    end

    // Assemble the read-only word from fixed ones and flags
    always_comb begin
        status             = FIXED;
        status[POS_TXCOMP] = flag_q[FL_TXCOMP];
        status[POS_RXRDY]  = flag_q[FL_RXRDY];
        status[POS_TXRDY]  = flag_q[FL_TXRDY];
        status[POS_NACK]   = flag_q[FL_NACK];
    end

    p_rx_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ev_rx_byte |=> status[POS_RXRDY]);
    p_rx_clr_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rhr_rd && !ev_rx_byte) |=> !status[POS_RXRDY]);
    p_nack_all_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_master && ev_nack) |=>
        (status[POS_TXCOMP] && status[POS_TXRDY] && status[POS_NACK]));
    p_msen_rdy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        msen_rise |=> status[POS_TXRDY]);
    p_m_comp_clr_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_master && ev_start && !ev_nack && !ev_stop_sent) |=> !status[POS_TXCOMP]);
    p_s_comp_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_master && ev_stop) |=> status[POS_TXCOMP]);
    p_s_rdy_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_master && thr_wr && !ev_tx_ack && !ev_nack && !msen_rise)
        |=> !status[POS_TXRDY]);

endmodule

// File: tb/tws_status_tb.sv
// Self-checking bench: vector table walked by one loop, then directed reset cases.
module tws_status_tb;

    localparam int CLK_PERIOD = 10;
    localparam int N_VEC      = 32;

    // Stimulus bit positions
    localparam logic [13:0] M  = 14'h0001; // mode_master
    localparam logic [13:0] EN = 14'h0002; // msen
    localparam logic [13:0] ST = 14'h0004; // start
    localparam logic [13:0] RS = 14'h0008; // repeated start
    localparam logic [13:0] SP = 14'h0010; // stop
    localparam logic [13:0] AD = 14'h0020; // address phase
    localparam logic [13:0] AH = 14'h0040; // address hit
    localparam logic [13:0] RX = 14'h0080; // byte received
    localparam logic [13:0] XF = 14'h0100; // holding to shifter
    localparam logic [13:0] AK = 14'h0200; // tx ack
    localparam logic [13:0] NK = 14'h0400; // nack
    localparam logic [13:0] SS = 14'h0800; // stop sent
    localparam logic [13:0] RD = 14'h1000; // rhr read
    localparam logic [13:0] WR = 14'h2000; // thr write

    // {stimulus, expected low half of status}; the upper half is expected zero
    localparam logic [29:0] VEC [N_VEC] = '{
        {M|EN,       16'hF00D}, // 0  R9 enable rise sets TXRDY
        {M|EN|WR,    16'hF009}, // 1  R7 write clears TXRDY
        {M|EN|ST,    16'hF008}, // 2  R3 start clears TXCOMP
        {M|EN|SS,    16'hF008}, // 3  R3 stop sent blocked by waiting byte
        {M|EN|XF,    16'hF00C}, // 4  R7 transfer sets TXRDY
        {M|EN|SS,    16'hF00D}, // 5  R3 stop sent with empty holding
        {M|EN|WR|XF, 16'hF00D}, // 6  R11 set wins over write
        {M|EN|RX,    16'hF00F}, // 7  R6 byte sets RXRDY
        {M|EN|RX,    16'hF00F}, // 8  R6 overrun keeps RXRDY
        {M|EN|RD|RX, 16'hF00F}, // 9  R6 read and byte together
        {M|EN|RD,    16'hF00D}, // 10 R6 read clears RXRDY
        {M|EN|ST,    16'hF00C}, // 11 R3 start
        {M|EN|WR,    16'hF008}, // 12 R7 write
        {M|EN|NK,    16'hF10D}, // 13 R8 NACK sets three flags
        {M|EN|ST,    16'hF00C}, // 14 R8 start clears NACK flag
        {EN|ST,      16'hF00C}, // 15 R4 slave start
        {EN|WR,      16'hF008}, // 16 R10 slave write clears TXRDY
        {EN|XF,      16'hF008}, // 17 R10 transfer ignored in slave
        {EN|AK,      16'hF00C}, // 18 R10 ack sets TXRDY
        {EN|SP,      16'hF00D}, // 19 R4 stop sets TXCOMP
        {EN|ST,      16'hF00C}, // 20 R4 start clears TXCOMP
        {EN|AD,      16'hF00C}, // 21 R5 mismatch without repeated start
        {EN|RS,      16'hF00C}, // 22 R5 repeated start
        {EN|AD|AH,   16'hF00C}, // 23 R5 matching address
        {EN|RS,      16'hF00C}, // 24 R5 repeated start
        {EN|AD,      16'hF00D}, // 25 R5 foreign address after repeated start
        {EN|ST,      16'hF00C}, // 26 R4 start
        {EN|WR,      16'hF008}, // 27 R10 write
        {EN|NK,      16'hF10C}, // 28 R10 NACK sets TXRDY, TXCOMP kept
        {14'h0000,   16'hF10C}, // 29 R9 enable drops, flags kept
        {WR,         16'hF108}, // 30 R10 write clears TXRDY
        {EN,         16'hF10C}  // 31 R9 enable rise in slave mode
    };

    logic        clk = 1'b0;
    logic        rst_n;
    logic [13:0] stim;
    logic [31:0] status;
    int          n_checks = 0;
    int          n_errors = 0;
    logic        done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tws_status u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .mode_master  (stim[0]),
        .msen         (stim[1]),
        .ev_start     (stim[2]),
        .ev_rstart    (stim[3]),
        .ev_stop      (stim[4]),
        .ev_addr      (stim[5]),
        .addr_hit     (stim[6]),
        .ev_rx_byte   (stim[7]),
        .ev_xfer      (stim[8]),
        .ev_tx_ack    (stim[9]),
        .ev_nack      (stim[10]),
        .ev_stop_sent (stim[11]),
        .rhr_rd       (stim[12]),
        .thr_wr       (stim[13]),
        .status       (status)
    );

    task automatic check(input string req, input logic [31:0] exp);
        n_checks++;
        if (status !== exp) begin
            n_errors++;
            $display("FAIL %s: status got %h expected %h", req, status, exp);
        end
    endtask

    initial begin
        rst_n = 1'b0;
        stim  = '0;
        @(negedge clk);
        @(negedge clk);
        check("R1 in reset", 32'h0000_F009);
        check("R2 fixed ones at reset", 32'h0000_F009);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after release", 32'h0000_F009);

        // Table walk: each vector lasts one cycle, result seen one edge later
        for (int i = 0; i < N_VEC; i++) begin
            stim = VEC[i][29:16];
            @(negedge clk);
            check($sformatf("R1-table vector %0d", i), {16'h0000, VEC[i][15:0]});
        end

        // Directed: reset mid-run with enable held high
        stim = M | EN | RX;
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 reset overrides events", 32'h0000_F009);
        stim = M | EN;
        rst_n = 1'b1;
        @(negedge clk);
        check("R9 enable held through reset", 32'h0000_F00D);
        stim = '0;
        @(negedge clk);
        check("R2 fixed ones with idle inputs", 32'h0000_F00D);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check
    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

endmodule